// File: doc/BRIEF.md
# Stream Command Engine with Burst Memory Write

This block sits behind a 32-bit valid/ready input stream and treats every word it receives as an instruction. Each instruction passes through a short cycle: the word is captured, decoded in a separate cycle, an optional response is transmitted, and a closing state follows. In that closing state the block can already take the next word.

Three opcodes are understood:

- A memory-write header announces a burst of raw data words. The header carries the burst length and the starting byte address. The data words are stored in an internal word RAM at rising word addresses.
- An LED opcode loads an output register.
- A read opcode fetches one RAM word and returns it on a 32-bit valid/ready output stream.

Words with any other opcode are dropped.

Top module: `stream_cmd_engine`

## Requirements
- R1: While the active-low asynchronous reset is applied, and directly after its release, `in_ready` is 1, `out_valid` is 0, `out_data` is 0 and `led` is 0.
- R2: A word is accepted only on a cycle where `in_valid` and `in_ready` are both 1. In the cycle after an acceptance, `in_ready` is 0 while the word is decoded.
- R3: Opcode 4'h3 in bits 31:28 is a memory-write header. Bits 27:24 hold N, and the next N+1 accepted words are stored as data. The first data word goes to the byte address in bits 23:0, and each following word goes 4 bytes higher. For example, header 3100_0004 followed by CAFE_BEEF and 1234_5678 stores those words at byte addresses 0x04 and 0x08.
- R4: A byte address selects the RAM word slot through its bits [ADDR_W-1:2] only. With ADDR_W=8, byte address 0x1F0 and byte address 0xF0 name the same slot.
- R5: Opcode 4'h1 in bits 31:28 loads `led` from bits 7:0 of the command. The new value is visible two cycles after the acceptance edge.
- R6: Opcode 4'h2 in bits 31:28 returns, on `out_data`, the RAM word at the byte address held in bits 23:0.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value. `in_ready` is 0 whenever `out_valid` is 1.
- R8: A word whose opcode is 4'h0 or anything from 4'h4 to 4'hF leaves `led` unchanged, produces no output word and does not block the next command.
- R9: Data words inside a burst are stored as they are, even if their top bits look like an opcode. They never change `led`.
- R10: A reset in the middle of a burst abandons the rest of the burst. The next accepted word is decoded as a command. RAM contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 32 | Input stream word |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Engine can accept a word |
| out_data | output | 32 | Response word, zero when not valid |
| out_valid | output | 1 | Response word present |
| out_ready | input | 1 | Downstream takes the response |
| led | output | LED_W | LED register loaded by opcode 4'h1 |

## Verification
The bench builds the engine with ADDR_W=8 and LED_W=8. That gives a 64-slot RAM, so a byte address one step above 0xFF already wraps onto a low slot, and the aliasing of R4 can be checked with a single write and read. A four-word burst (N=3) and a reset placed after its first data word exercise both count tracking and burst abandonment. The LED width of 8 means an LED-looking data word can set every LED bit, so a wrongly decoded burst word would show up on `led`.

// File: rtl/stream_cmd_pkg.sv
package stream_cmd_pkg;

    localparam int WORD_W = 32;
    localparam int OP_HI  = 31;
    localparam int OP_LO  = 28;
    localparam int CNT_HI = 27;
    localparam int CNT_LO = 24;
    localparam int BA_W   = 24;

    typedef enum logic [3:0] {
        OPC_LED  = 4'h1,
        OPC_READ = 4'h2,
        OPC_MEMW = 4'h3
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH = 3'd0,
        ST_LOAD  = 3'd1,
        ST_TX    = 3'd2,
        ST_DONE  = 3'd3
    } eng_state_e;

endpackage

// File: rtl/cmd_field_decode.sv
module cmd_field_decode
    import stream_cmd_pkg::*;
#(
    parameter int LED_W = 8
) (
    input  logic [WORD_W-1:0]          word_i,
    output logic [3:0]                 op_o,
    output logic [CNT_HI-CNT_LO:0]     cnt_o,
    output logic [BA_W-1:0]            addr_o,
    output logic [LED_W-1:0]           led_o
);
    always_comb begin
        op_o   = word_i[OP_HI:OP_LO];
        cnt_o  = word_i[CNT_HI:CNT_LO];
        addr_o = word_i[BA_W-1:0];
        led_o  = word_i[LED_W-1:0];
    end
endmodule

// File: rtl/cmd_word_ram.sv
module cmd_word_ram #(
    parameter int SLOT_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [SLOT_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SLOT_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << SLOT_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        rdata <= mem_q[raddr];
    end
endmodule

// File: rtl/stream_cmd_engine.sv
module stream_cmd_engine
    import stream_cmd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LED_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [31:0]       out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [LED_W-1:0]  led
);
    localparam int SLOT_W = ADDR_W - 2;
    localparam int CNT_W  = CNT_HI - CNT_LO + 1;

    typedef struct packed {
        eng_state_e        st;
        logic [WORD_W-1:0] word;
        logic [BA_W-1:0]   addr;
        logic [CNT_W-1:0]  left;
        logic              burst;
        logic [LED_W-1:0]  led;
    } regs_t;

    regs_t r_d, r_q;

    logic [3:0]        dec_op;
    logic [CNT_W-1:0]  dec_cnt;
    logic [BA_W-1:0]   dec_addr;
    logic [LED_W-1:0]  dec_led;
    logic              ram_we;
    logic [WORD_W-1:0] ram_rdata;

    cmd_field_decode #(.LED_W(LED_W)) u_dec (
        .word_i (r_q.word),
        .op_o   (dec_op),
        .cnt_o  (dec_cnt),
        .addr_o (dec_addr),
        .led_o  (dec_led)
    );

    cmd_word_ram #(.SLOT_W(SLOT_W), .DATA_W(WORD_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (r_q.addr[ADDR_W-1:2]),
        .wdata (r_q.word),
        .raddr (dec_addr[ADDR_W-1:2]),
        .rdata (ram_rdata)
    );

    always_comb begin
        r_d       = r_q;
        ram_we    = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (r_q.st)
            ST_FETCH: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.word = in_data;
                    r_d.st   = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (r_q.burst) begin
                    ram_we    = 1'b1;
                    r_d.addr  = r_q.addr + BA_W'(4);
                    r_d.left  = r_q.left - CNT_W'(1);
                    r_d.burst = (r_q.left != '0);
                    r_d.st    = ST_DONE;
                end else begin
                    unique case (dec_op)
                        OPC_MEMW: begin
                            r_d.burst = 1'b1;
                            r_d.left  = dec_cnt;
                            r_d.addr  = dec_addr;
                            r_d.st    = ST_DONE;
                        end
                        OPC_LED: begin
                            r_d.led = dec_led;
                            r_d.st  = ST_DONE;
                        end
                        OPC_READ: r_d.st = ST_TX;
                        default:  r_d.st = ST_FETCH;
                    endcase
                end
            end
            ST_TX: begin
                out_valid = 1'b1;
                if (out_ready) r_d.st = ST_DONE;
            end
            ST_DONE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.word = in_data;
                    r_d.st   = ST_LOAD;
                end else begin
                    r_d.st = ST_FETCH;
                end
            end
            default: r_d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_FETCH;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_data = out_valid ? ram_rdata : '0;
    assign led      = r_q.led;

    // R2
    load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R7
    hold_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R3
    wr_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (in_ready && !out_valid));

    // R5
    led_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led) |-> $past(in_valid && in_ready, 2));

endmodule

// File: tb/test_stream_cmd_engine.sv
module test_stream_cmd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  led;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    stream_cmd_engine #(.ADDR_W(8), .LED_W(8)) i_stream_cmd_engine (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .led(led)
    );

    always #5 clk = ~clk;

    // {byte address, data}
    localparam logic [55:0] VEC [8] = '{
        {24'h000000, 32'h0000_0001}, {24'h000010, 32'hDEAD_0010},
        {24'h000020, 32'h3FFF_FFFF}, {24'h000030, 32'h2000_0030},
        {24'h00003C, 32'hA5A5_5A5A}, {24'h000080, 32'h8000_0000},
        {24'h0000A4, 32'h1234_ABCD}, {24'h0000FC, 32'hFFFF_FFFF}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        logic hs;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        forever begin
            hs = in_ready;
            @(negedge clk);
            if (hs) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic recv(input logic [31:0] exp, input string tag);
        out_ready = 1'b1;
        while (!out_valid) @(negedge clk);
        check(out_data, exp, tag);
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++; checks++;
                $display("FAIL watchdog actual %0d expected <100000", cycles);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] held;
        idle(2);
        // R1: during reset
        check({31'd0, in_ready}, 32'd1, "R1 in_ready in reset");
        check({31'd0, out_valid}, 32'd0, "R1 out_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check({24'd0, led}, 32'd0, "R1 led after reset");
        check(out_data, 32'd0, "R1 out_data after reset");

        // table: single-word writes then reads (R3, R6)
        for (int k = 0; k < 8; k++) begin
            send({8'h30, VEC[k][55:32]});
            send(VEC[k][31:0]);
            send({8'h20, VEC[k][55:32]});
            recv(VEC[k][31:0], "R6 table read");
        end

        // R3: two-word burst example
        send(32'h3100_0004);
        send(32'hCAFE_BEEF);
        send(32'h1234_5678);
        send(32'h2000_0004);
        recv(32'hCAFE_BEEF, "R3 burst word 0");
        send(32'h2000_0008);
        recv(32'h1234_5678, "R3 burst word 1");

        // R4: 0x1F0 aliases 0xF0
        send(32'h3000_01F0);
        send(32'h0BAD_F00D);
        send(32'h2000_00F0);
        recv(32'h0BAD_F00D, "R4 alias slot");

        // R5 and R2
        send(32'h1000_00C3);
        check({31'd0, in_ready}, 32'd0, "R2 in_ready low in decode");
        @(negedge clk);
        check({24'd0, led}, 32'h0000_00C3, "R5 led load");

        // R8: unknown opcodes
        send(32'h7000_0055);
        send(32'h0000_0066);
        idle(3);
        check({24'd0, led}, 32'h0000_00C3, "R8 led unchanged");
        check({31'd0, out_valid}, 32'd0, "R8 no output");
        send(32'h2000_0010);
        recv(32'hDEAD_0010, "R8 next command works");

        // R9: LED-looking data inside a burst
        send(32'h3000_0040);
        send(32'h1000_00FF);
        idle(2);
        check({24'd0, led}, 32'h0000_00C3, "R9 data not decoded");
        send(32'h2000_0040);
        recv(32'h1000_00FF, "R9 data stored raw");

        // R7: backpressure
        send(32'h2000_0080);
        while (!out_valid) @(negedge clk);
        held = out_data;
        idle(3);
        check({31'd0, out_valid}, 32'd1, "R7 valid held");
        check(out_data, held, "R7 data stable");
        check({31'd0, in_ready}, 32'd0, "R7 no input while valid");
        recv(32'h8000_0000, "R7 data after release");

        // R10: reset mid-burst
        send(32'h3300_0048);
        send(32'h1111_1111);
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        send(32'h1000_0033);
        @(negedge clk);
        check({24'd0, led}, 32'h0000_0033, "R10 next word is command");
        send(32'h2000_0048);
        recv(32'h1111_1111, "R10 ram kept");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule